// File: doc/BRIEF.md
# Complementary PWM Dead-Time Output Stage

This block turns a single reference PWM waveform into a pair of complementary pin drives, a main output and its complement. At every edge of the reference, the output that is about to turn on is held off for a programmable dead time, while the output that is turning off drops at once. The two outputs are therefore never active at the same time. The dead time is set by an 8-bit code whose scale is piecewise: the upper code bits pick one of four ranges, each with its own step size. The time is counted in ticks of a dead-time clock enable.

After dead-time insertion, a pin stage applies a per-output polarity and decides whether each pin is driven or released. A global output enable, per-output channel enables, per-output idle levels and an idle-mode off-state select control this stage. While the global enable is low, the off-state select chooses between releasing both pins and driving each enabled pin at its idle level. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `cpwm_deadband_stage`

## Requirements
- R1: When code bit 7 is 0, the delayed output asserts exactly `code` ticks after the reference edge, so codes from 0 to 127 give 0 to 127 ticks.
- R2: When code bits 7:6 are `10`, the delay is (64 + code[5:0]) × 2 ticks, which spans 128 to 254.
- R3: When code bits 7:5 are `110`, the delay is (32 + code[4:0]) × 8 ticks, which spans 256 to 504.
- R4: When code bits 7:5 are `111`, the delay is (32 + code[4:0]) × 16 ticks, which spans 512 to 1008.
- R5: Code 0 gives no delay. The output that is turning on changes on the first clock edge that samples the new reference level, just as the other output turns off.
- R6: Each leg output becomes inactive on the first clock edge that samples its own input as inactive. A rising reference turns the complement off and a falling reference turns the main output off, both without delay. While reset is held, both legs are inactive.
- R7: If the reference stays in one state for fewer ticks than the dead time, the output that would have turned on stays off for that whole pulse.
- R8: The dead-time count advances only on clock edges where `tick_en` is 1. With `tick_en` held at 0 and a nonzero dead time, the delayed output does not assert.
- R9: Polarity is applied after dead-time insertion. The active level of a pin is the inverse of its polarity bit (pin = leg ^ pol). With the global enable and both channel enables set, the two pins are never active together, for either polarity setting.
- R10: When `main_en` is 0 and `off_idle_sel` is 0, both `pin_main_oe` and `pin_comp_oe` are 0.
- R11: When `main_en` is 0 and `off_idle_sel` is 1, each pin's enable equals its channel enable, and an enabled pin shows its idle level.
- R12: When `main_en` is 1 and a channel enable is 0, that pin's enable is 0 and the pin shows its idle level, while the other pin keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Dead-time tick enable |
| dt_code | input | 8 | Non-linear dead-time code |
| ref_pwm | input | 1 | Reference PWM waveform |
| main_en | input | 1 | Global output enable |
| off_idle_sel | input | 1 | Off-state select while `main_en` is 0 |
| ch_en_main | input | 1 | Main channel enable |
| ch_en_comp | input | 1 | Complement channel enable |
| pol_main | input | 1 | Main pin polarity (1 inverts) |
| pol_comp | input | 1 | Complement pin polarity (1 inverts) |
| idle_main | input | 1 | Main pin idle level |
| idle_comp | input | 1 | Complement pin idle level |
| pin_main | output | 1 | Main pin level |
| pin_comp | output | 1 | Complement pin level |
| pin_main_oe | output | 1 | Main pin drive enable |
| pin_comp_oe | output | 1 | Complement pin drive enable |

## Verification
Errors in the count or the range decoding move the turn-on edge of a pin. Such an error shows up in the first dead band after the code is applied, as a turn-on that comes early or late by a whole number of cycles. A stuck or stale leg state appears as a pin that turns on when it should have been suppressed, or as an overlap of the two active levels. The overlap is seen on the same clock edge. The gating faults in the pin stage are combinational, so the wrong pin level or enable is visible in the same cycle as the control change.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CODE_W = 8;
  localparam int DT_W   = 10;   // holds up to 1008 ticks
  localparam int N_LEGS = 2;

  typedef enum logic [1:0] {
    RNG_UNIT = 2'd0,
    RNG_X2   = 2'd1,
    RNG_X8   = 2'd2,
    RNG_X16  = 2'd3
  } dt_range_e;
endpackage

// File: rtl/cpwm_dt_decode.sv
module cpwm_dt_decode
  import cpwm_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int TW = DT_W
) (
  input  logic [CW-1:0] code,
  output logic [TW-1:0] dt_ticks
);
  dt_range_e rng;

  always_comb begin
    if (!code[7])      rng = RNG_UNIT;
    else if (!code[6]) rng = RNG_X2;
    else if (!code[5]) rng = RNG_X8;
    else               rng = RNG_X16;
  end

  // The offsets of 64 and 32 are exact powers of two, so each range is
  // built by concatenation and needs no adder.
  always_comb begin
    case (rng)
      RNG_UNIT: dt_ticks = TW'(code[6:0]);
      RNG_X2:   dt_ticks = TW'({1'b1, code[5:0], 1'b0});
      RNG_X8:   dt_ticks = TW'({1'b1, code[4:0], 3'b000});
      default:  dt_ticks = TW'({1'b1, code[4:0], 4'b0000});
    endcase
  end
endmodule

// File: rtl/cpwm_dt_leg.sv
module cpwm_dt_leg
  import cpwm_pkg::*;
#(
  parameter int TW = DT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          lvl_in,
  input  logic [TW-1:0] dt_ticks,
  output logic          act
);
  logic          act_q, act_nx;
  logic [TW-1:0] cnt_q, cnt_nx;

  always_comb begin
    act_nx = act_q;
    cnt_nx = cnt_q;
    if (!lvl_in) begin
      act_nx = 1'b0;
      cnt_nx = '0;
    end else if (!act_q) begin
      if (cnt_q >= dt_ticks) begin
        act_nx = 1'b1;
      end else if (tick_en) begin
        cnt_nx = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/cpwm_pin_drive.sv
module cpwm_pin_drive (
  input  logic act,
  input  logic main_en,
  input  logic off_idle_sel,
  input  logic ch_en,
  input  logic pol,
  input  logic idle_lvl,
  output logic pin,
  output logic oe
);
  always_comb begin
    if (main_en) begin
      oe  = ch_en;
      pin = ch_en ? (act ^ pol) : idle_lvl;
    end else begin
      oe  = off_idle_sel & ch_en;
      pin = idle_lvl;
    end
  end
endmodule

// File: rtl/cpwm_deadband_stage.sv
module cpwm_deadband_stage
  import cpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] dt_code,
  input  logic              ref_pwm,
  input  logic              main_en,
  input  logic              off_idle_sel,
  input  logic              ch_en_main,
  input  logic              ch_en_comp,
  input  logic              pol_main,
  input  logic              pol_comp,
  input  logic              idle_main,
  input  logic              idle_comp,
  output logic              pin_main,
  output logic              pin_comp,
  output logic              pin_main_oe,
  output logic              pin_comp_oe
);
  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic [DT_W-1:0]   dt_ticks;
  logic [N_LEGS-1:0] leg_in, leg_act, en_v, pol_v, idle_v, pin_v, oe_v;

  // Reset is asserted asynchronously and released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  cpwm_dt_decode #(.CW(CODE_W), .TW(DT_W)) dec_i (
    .code     (dt_code),
    .dt_ticks (dt_ticks)
  );

  assign leg_in = {~ref_pwm, ref_pwm};   // leg 0 main, leg 1 complement
  assign en_v   = {ch_en_comp, ch_en_main};
  assign pol_v  = {pol_comp,   pol_main};
  assign idle_v = {idle_comp,  idle_main};

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    cpwm_dt_leg #(.TW(DT_W)) leg_i (
      .clk      (clk),
      .rst_n    (rst_s),
      .tick_en  (tick_en),
      .lvl_in   (leg_in[g]),
      .dt_ticks (dt_ticks),
      .act      (leg_act[g])
    );
    cpwm_pin_drive drv_i (
      .act          (leg_act[g]),
      .main_en      (main_en),
      .off_idle_sel (off_idle_sel),
      .ch_en        (en_v[g]),
      .pol          (pol_v[g]),
      .idle_lvl     (idle_v[g]),
      .pin          (pin_v[g]),
      .oe           (oe_v[g])
    );
  end

  assign pin_main    = pin_v[0];
  assign pin_comp    = pin_v[1];
  assign pin_main_oe = oe_v[0];
  assign pin_comp_oe = oe_v[1];
endmodule

// File: rtl/cpwm_deadband_stage_chk.sv
module cpwm_deadband_stage_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_pwm,
  input logic [CW-1:0] dt_code,
  input logic          main_en,
  input logic          off_idle_sel,
  input logic          ch_en_main,
  input logic          ch_en_comp,
  input logic          pol_main,
  input logic          pol_comp,
  input logic          idle_main,
  input logic          pin_main,
  input logic          pin_comp,
  input logic          pin_main_oe,
  input logic          pin_comp_oe,
  input logic          main_act,
  input logic          comp_act
);
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (main_en && ch_en_main && ch_en_comp) |->
      !((pin_main ^ pol_main) && (pin_comp ^ pol_comp)));

  p_main_off_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_pwm) |=> !main_act);

  p_comp_off_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_pwm) |=> !comp_act);

  p_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ref_pwm) && dt_code == '0) |=> main_act);

  p_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_en && !off_idle_sel) |-> (!pin_main_oe && !pin_comp_oe));

  p_idle_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_en && off_idle_sel && ch_en_main) |-> (pin_main_oe && pin_main == idle_main));
endmodule

bind cpwm_deadband_stage cpwm_deadband_stage_chk #(.CW(cpwm_pkg::CODE_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_s),
  .ref_pwm      (ref_pwm),
  .dt_code      (dt_code),
  .main_en      (main_en),
  .off_idle_sel (off_idle_sel),
  .ch_en_main   (ch_en_main),
  .ch_en_comp   (ch_en_comp),
  .pol_main     (pol_main),
  .pol_comp     (pol_comp),
  .idle_main    (idle_main),
  .pin_main     (pin_main),
  .pin_comp     (pin_comp),
  .pin_main_oe  (pin_main_oe),
  .pin_comp_oe  (pin_comp_oe),
  .main_act     (leg_act[0]),
  .comp_act     (leg_act[1])
);

// File: tb/cpwm_deadband_stage_tb_top.sv
`timescale 1ns/1ps
module cpwm_deadband_stage_tb_top;
  logic clk = 1'b0;
  logic rst_n, tick_en, ref_pwm, main_en, off_idle_sel;
  logic ch_en_main, ch_en_comp, pol_main, pol_comp, idle_main, idle_comp;
  logic [7:0] dt_code;
  logic pin_main, pin_comp, pin_main_oe, pin_comp_oe;

  always #10 clk = ~clk;

  cpwm_deadband_stage dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dt_code(dt_code),
    .ref_pwm(ref_pwm), .main_en(main_en), .off_idle_sel(off_idle_sel),
    .ch_en_main(ch_en_main), .ch_en_comp(ch_en_comp),
    .pol_main(pol_main), .pol_comp(pol_comp),
    .idle_main(idle_main), .idle_comp(idle_comp),
    .pin_main(pin_main), .pin_comp(pin_comp),
    .pin_main_oe(pin_main_oe), .pin_comp_oe(pin_comp_oe)
  );

  typedef struct {
    bit    lvl;
    int    cyc;
    string req;
  } exp_item_t;

  exp_item_t q_main[$];
  exp_item_t q_comp[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit mon_on = 1'b0;
  bit prev_m, prev_c;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Monitor: watch active levels of both legs at the pins, pop expectations.
  always @(negedge clk) begin
    bit am, ac;
    exp_item_t it;
    am = pin_main ^ pol_main;
    ac = pin_comp ^ pol_comp;
    if (mon_on && am != prev_m) begin
      n_cmp++;
      if (q_main.size() == 0) begin
        n_bad++;
        $display("FAIL R7 main changed unexpectedly at cycle %0d: actual %b expected %b", cyc, am, prev_m);
      end else begin
        it = q_main.pop_front();
        if (it.lvl != am || it.cyc != cyc) begin
          n_bad++;
          $display("FAIL %s main edge: actual lvl %b cycle %0d expected lvl %b cycle %0d",
                   it.req, am, cyc, it.lvl, it.cyc);
        end
      end
    end
    if (mon_on && ac != prev_c) begin
      n_cmp++;
      if (q_comp.size() == 0) begin
        n_bad++;
        $display("FAIL R9 comp changed unexpectedly at cycle %0d: actual %b expected %b", cyc, ac, prev_c);
      end else begin
        it = q_comp.pop_front();
        if (it.lvl != ac || it.cyc != cyc) begin
          n_bad++;
          $display("FAIL %s comp edge: actual lvl %b cycle %0d expected lvl %b cycle %0d",
                   it.req, ac, cyc, it.lvl, it.cyc);
        end
      end
    end
    prev_m = am;
    prev_c = ac;
  end

  task automatic push_m(bit lvl, int c, string req);
    exp_item_t it;
    it.lvl = lvl; it.cyc = c; it.req = req;
    q_main.push_back(it);
  endtask

  task automatic push_c(bit lvl, int c, string req);
    exp_item_t it;
    it.lvl = lvl; it.cyc = c; it.req = req;
    q_comp.push_back(it);
  endtask

  // One full reference period with tick_en held high; dt is the expected tick count.
  task automatic pulse(logic [7:0] code, int dt, string req);
    @(negedge clk);
    dt_code = code;
    repeat (2) @(negedge clk);
    ref_pwm = 1'b1;
    push_m(1'b1, cyc + 1 + dt, req);
    push_c(1'b0, cyc + 1, "R6");
    repeat (dt + 20) @(negedge clk);
    ref_pwm = 1'b0;
    push_m(1'b0, cyc + 1, "R6");
    push_c(1'b1, cyc + 1 + dt, req);
    repeat (dt + 20) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; ref_pwm = 1'b0; dt_code = 8'd0;
    main_en = 1'b1; off_idle_sel = 1'b0; ch_en_main = 1'b1; ch_en_comp = 1'b1;
    pol_main = 1'b0; pol_comp = 1'b0; idle_main = 1'b0; idle_comp = 1'b0;
    repeat (3) @(negedge clk);
    // R6: both legs inactive in reset
    check("R6", "reset pin_main", pin_main, 1'b0);
    check("R6", "reset pin_comp", pin_comp, 1'b0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R6", "comp active after reset", pin_comp, 1'b1);
    mon_on = 1'b1;

    pulse(8'h00, 0,    "R5");
    pulse(8'h05, 5,    "R1");
    pulse(8'h7F, 127,  "R1");
    pulse(8'h80, 128,  "R2");
    pulse(8'hBF, 254,  "R2");
    pulse(8'hC0, 256,  "R3");
    pulse(8'hDF, 504,  "R3");
    pulse(8'hE0, 512,  "R4");
    pulse(8'hFF, 1008, "R4");

    // R7: high for 5 cycles with a 10-tick dead time; main must stay off
    dt_code = 8'd10;
    repeat (3) @(negedge clk);
    ref_pwm = 1'b1;
    push_c(1'b0, cyc + 1, "R6");
    repeat (5) @(negedge clk);
    ref_pwm = 1'b0;
    push_c(1'b1, cyc + 1 + 10, "R7");
    repeat (30) @(negedge clk);
    check("R7", "main after short pulse", pin_main, 1'b0);

    // R8: no ticks, no turn-on
    dt_code = 8'd3;
    tick_en = 1'b0;
    @(negedge clk);
    ref_pwm = 1'b1;
    push_c(1'b0, cyc + 1, "R6");
    repeat (20) @(negedge clk);
    check("R8", "main held without ticks", pin_main, 1'b0);
    tick_en = 1'b1;
    push_m(1'b1, cyc + 1 + 3, "R8");
    repeat (10) @(negedge clk);
    ref_pwm = 1'b0;
    push_m(1'b0, cyc + 1, "R6");
    push_c(1'b1, cyc + 1 + 3, "R8");
    repeat (10) @(negedge clk);

    // R9: inverted polarity, dead band shows both pins at inactive level 1
    mon_on = 1'b0;
    pol_main = 1'b1; pol_comp = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;
    check("R9", "inverted comp active level", pin_comp, 1'b0);
    dt_code = 8'd8;
    @(negedge clk);
    ref_pwm = 1'b1;
    push_m(1'b1, cyc + 1 + 8, "R9");
    push_c(1'b0, cyc + 1, "R9");
    repeat (4) @(negedge clk);
    check("R9", "dead band pin_main", pin_main, 1'b1);
    check("R9", "dead band pin_comp", pin_comp, 1'b1);
    repeat (20) @(negedge clk);
    check("R9", "inverted main active", pin_main, 1'b0);
    ref_pwm = 1'b0;
    push_m(1'b0, cyc + 1, "R9");
    push_c(1'b1, cyc + 1 + 8, "R9");
    repeat (20) @(negedge clk);
    mon_on = 1'b0;
    pol_main = 1'b0; pol_comp = 1'b0;

    // R10: global enable low, off-state select low
    main_en = 1'b0; off_idle_sel = 1'b0;
    @(negedge clk);
    check("R10", "main oe released", pin_main_oe, 1'b0);
    check("R10", "comp oe released", pin_comp_oe, 1'b0);

    // R11: idle drive
    off_idle_sel = 1'b1; idle_main = 1'b1; idle_comp = 1'b0; ch_en_comp = 1'b0;
    @(negedge clk);
    check("R11", "main oe idle", pin_main_oe, 1'b1);
    check("R11", "main idle level", pin_main, 1'b1);
    check("R11", "comp oe disabled chan", pin_comp_oe, 1'b0);
    idle_main = 1'b0; idle_comp = 1'b1; ch_en_comp = 1'b1;
    @(negedge clk);
    check("R11", "comp oe idle", pin_comp_oe, 1'b1);
    check("R11", "comp idle level", pin_comp, 1'b1);
    check("R11", "main idle level low", pin_main, 1'b0);

    // R12: running, main channel disabled; comp leg active (ref low)
    main_en = 1'b1; ch_en_main = 1'b0; idle_main = 1'b1;
    @(negedge clk);
    check("R12", "main oe off", pin_main_oe, 1'b0);
    check("R12", "main idle level", pin_main, 1'b1);
    check("R12", "comp oe on", pin_comp_oe, 1'b1);
    check("R12", "comp running", pin_comp, 1'b1);

    repeat (5) @(negedge clk);
    n_cmp++;
    if (q_main.size() != 0 || q_comp.size() != 0) begin
      n_bad++;
      $display("FAIL R6 pending edges: actual %0d/%0d expected 0/0", q_main.size(), q_comp.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule